// File: doc/BRIEF.md
# Subevent Size and Header Validator

This block sits in a 16-bit readout stream between the source of subevents and the logic that packs each subevent into one UDP datagram. Each subevent opens with four header words: a byte count, a decoding word, an identifier and a trigger number. It closes with a 32-bit error word carried as two stream words, low half first and high half last. The block checks the declared byte count against a programmable window and checks that the header is self-consistent. It forwards every word whatever the outcome. A subevent that fails either check is marked by setting bit 26 of its closing error word, which is bit 10 of the final stream word.

The decision is made as the final word passes, so the mark is applied in place through a single output register and no subevent buffer is needed. A subevent that ends before the word count its header declares is treated as a header failure. Its final word is replaced by a synthesized error half that has only the flag set. Saturating statistics counters and the two window limits sit behind a small register port.

Top module: `subev_validator`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, the lower limit (address 0) reads 16, the upper limit (address 1) reads 65535, and counter addresses 3 to 6 read 0.
- R2: Every accepted input word appears once on the output, in order, one cycle after acceptance, with its start (out_sos) and end (out_eos) markers. Every word except the final word of a subevent is unchanged.
- R3: If a subevent of at least 3 words declares a byte count (word 0) below the lower limit or above the upper limit, bit 10 of its final word is set on output.
- R4: If a subevent of at least 3 words has a byte count that is not a multiple of 4, a byte count below 16, or a decoding word (word 1) whose bits 15..8 differ from 8'h02, bit 10 of its final word is set on output.
- R5: A subevent that passes every check has its final word forwarded unchanged, including a bit 10 that is already set.
- R6: A subevent with fewer than 3 words, or with fewer words than its byte count divided by 2 (rounded down), has its final word replaced by 16'h0400.
- R7: Address 3 reads the count of window undersize cases in bits 15..0 and the count of window oversize cases in bits 31..16.
- R8: Address 4 reads the count of header failures (the R4 and R6 cases). Address 5 reads the count of byte-count faults, which are the non-multiple-of-4 and below-16 cases of subevents with at least 3 words.
- R9: Address 6 reads the number of input words accepted since the last clear.
- R10: Writing any value to address 2 zeroes all counters in the next cycle. The limits are left unchanged.
- R11: While out_valid is 1 and out_ready is 0, in_ready is 0 and the output word is held. No word is lost under backpressure.
- R12: Values written to addresses 0 and 1 read back and set the window used for subevents that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 16 | Input word |
| in_sos | input | 1 | Input word is the first of a subevent |
| in_eos | input | 1 | Input word is the last of a subevent |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | 16 | Output word, with the final word possibly patched |
| out_sos | output | 1 | Output word is the first of a subevent |
| out_eos | output | 1 | Output word is the last of a subevent |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |

## Verification
A corrupt word index or a stale captured byte count or format byte would show on the final word of the affected subevent. That word appears one cycle after the closing input word is accepted, either with a flag that should not be there or with a flag missing. The reference model compares it on that cycle. The same fault leaves a counter off by one, which the next register read exposes. A lost or doubled word under backpressure misaligns the expected stream at once, so every later word mismatches.

// File: rtl/subev_pkg.sv
package subev_pkg;

    typedef logic [15:0] word_t;

    // Outcome of the checks, meaningful when done is set
    typedef struct packed {
        logic done;
        logic under;
        logic over;
        logic bad_hdr;
        logic bad_size;
    } verdict_t;

    localparam int    FLAG_POS   = 10;        // bit 26 of the 32-bit error word
    localparam word_t TRUNC_WORD = 16'h0400;  // synthesized closing half

    localparam logic [2:0] ADR_MIN   = 3'd0;
    localparam logic [2:0] ADR_MAX   = 3'd1;
    localparam logic [2:0] ADR_CLR   = 3'd2;
    localparam logic [2:0] ADR_SIZE  = 3'd3;
    localparam logic [2:0] ADR_HDR   = 3'd4;
    localparam logic [2:0] ADR_HSZ   = 3'd5;
    localparam logic [2:0] ADR_WORDS = 3'd6;

endpackage

// File: rtl/subev_satcnt.sv
module subev_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (inc && count != '1)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/subev_verdict.sv
module subev_verdict
    import subev_pkg::*;
#(
    parameter logic [7:0] FMT_CODE = 8'h02,
    parameter int         HDR_MIN  = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc,
    input  word_t       in_data,
    input  logic        in_sos,
    input  logic        in_eos,
    input  logic [31:0] lim_min,
    input  logic [31:0] lim_max,
    output word_t       word_out,
    output verdict_t    verdict
);
    logic [15:0] idx_q, cur_idx;
    word_t       size_q;
    logic [7:0]  fmt_q;
    logic        hdr_seen, trunc, size_bad, fmt_bad, under, over, flag;

    assign cur_idx = in_sos ? 16'd0 : idx_q;

    always_comb begin
        hdr_seen = cur_idx >= 16'd2;
        trunc    = !hdr_seen || (({1'b0, cur_idx} + 17'd1) < {2'b00, size_q[15:1]});
        size_bad = (size_q[1:0] != 2'b00) || (size_q < 16'(HDR_MIN));
        fmt_bad  = fmt_q != FMT_CODE;
        under    = hdr_seen && ({16'd0, size_q} < lim_min);
        over     = hdr_seen && ({16'd0, size_q} > lim_max);
        flag     = trunc || under || over || (hdr_seen && (size_bad || fmt_bad));

        word_out = in_data;
        if (in_eos) begin
            if (trunc)
                word_out = TRUNC_WORD;
            else if (flag)
                word_out[FLAG_POS] = 1'b1;
        end

        verdict.done     = acc && in_eos;
        verdict.under    = under;
        verdict.over     = over;
        verdict.bad_hdr  = trunc || (hdr_seen && (size_bad || fmt_bad));
        verdict.bad_size = hdr_seen && size_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            size_q <= '0;
            fmt_q  <= '0;
        end else if (acc) begin
            if (in_eos)
                idx_q <= '0;
            else if (cur_idx != 16'hFFFF)
                idx_q <= cur_idx + 16'd1;
            if (cur_idx == 16'd0) size_q <= in_data;
            if (cur_idx == 16'd1) fmt_q  <= in_data[15:8];
        end
    end
endmodule

// File: rtl/subev_stats.sv
module subev_stats
    import subev_pkg::*;
#(
    parameter int SZ_W  = 16,
    parameter int HDR_W = 32,
    parameter int HSZ_W = 16,
    parameter int WRD_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             word_acc,
    input  verdict_t         v,
    output logic [SZ_W-1:0]  n_under,
    output logic [SZ_W-1:0]  n_over,
    output logic [HDR_W-1:0] n_badhdr,
    output logic [HSZ_W-1:0] n_badsize,
    output logic [WRD_W-1:0] n_words
);
    subev_satcnt #(.W(SZ_W)) u_under (
        .clk(clk), .rst(rst), .clr(clr), .inc(v.done && v.under), .count(n_under));
    subev_satcnt #(.W(SZ_W)) u_over (
        .clk(clk), .rst(rst), .clr(clr), .inc(v.done && v.over), .count(n_over));
    subev_satcnt #(.W(HDR_W)) u_hdr (
        .clk(clk), .rst(rst), .clr(clr), .inc(v.done && v.bad_hdr), .count(n_badhdr));
    subev_satcnt #(.W(HSZ_W)) u_hsz (
        .clk(clk), .rst(rst), .clr(clr), .inc(v.done && v.bad_size), .count(n_badsize));
    subev_satcnt #(.W(WRD_W)) u_words (
        .clk(clk), .rst(rst), .clr(clr), .inc(word_acc), .count(n_words));
endmodule

// File: rtl/subev_validator.sv
module subev_validator
    import subev_pkg::*;
#(
    parameter logic [7:0] FMT_CODE   = 8'h02,
    parameter int         HDR_MIN    = 16,
    parameter int         SZ_CNT_W   = 16,
    parameter int         HDR_CNT_W  = 32,
    parameter int         HSZ_CNT_W  = 16,
    parameter int         WORD_CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_data,
    input  logic        in_sos,
    input  logic        in_eos,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [15:0] out_data,
    output logic        out_sos,
    output logic        out_eos,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    localparam logic [31:0] MIN_RST = 32'(HDR_MIN);
    localparam logic [31:0] MAX_RST = 32'd65535;

    logic [31:0] lim_min, lim_max;
    logic        acc, clr;
    word_t       patched;
    verdict_t    verdict;

    logic [SZ_CNT_W-1:0]   n_under, n_over;
    logic [HDR_CNT_W-1:0]  n_badhdr;
    logic [HSZ_CNT_W-1:0]  n_badsize;
    logic [WORD_CNT_W-1:0] n_words;

    assign in_ready = !out_valid || out_ready;
    assign acc      = in_valid && in_ready;
    assign clr      = reg_wr && (reg_addr == ADR_CLR);

    subev_verdict #(.FMT_CODE(FMT_CODE), .HDR_MIN(HDR_MIN)) u_verdict (
        .clk(clk), .rst(rst), .acc(acc), .in_data(in_data), .in_sos(in_sos),
        .in_eos(in_eos), .lim_min(lim_min), .lim_max(lim_max),
        .word_out(patched), .verdict(verdict));

    subev_stats #(.SZ_W(SZ_CNT_W), .HDR_W(HDR_CNT_W), .HSZ_W(HSZ_CNT_W),
                  .WRD_W(WORD_CNT_W)) u_stats (
        .clk(clk), .rst(rst), .clr(clr), .word_acc(acc), .v(verdict),
        .n_under(n_under), .n_over(n_over), .n_badhdr(n_badhdr),
        .n_badsize(n_badsize), .n_words(n_words));

    // Output register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sos   <= 1'b0;
            out_eos   <= 1'b0;
        end else if (acc) begin
            out_valid <= 1'b1;
            out_data  <= patched;
            out_sos   <= in_sos;
            out_eos   <= in_eos;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Window limits
    always_ff @(posedge clk) begin
        if (rst) begin
            lim_min <= MIN_RST;
            lim_max <= MAX_RST;
        end else if (reg_wr) begin
            if (reg_addr == ADR_MIN) lim_min <= reg_wdata;
            if (reg_addr == ADR_MAX) lim_max <= reg_wdata;
        end
    end

    always_comb begin
        case (reg_addr)
            ADR_MIN:   reg_rdata = lim_min;
            ADR_MAX:   reg_rdata = lim_max;
            ADR_SIZE:  reg_rdata = 32'({n_over, n_under});
            ADR_HDR:   reg_rdata = 32'(n_badhdr);
            ADR_HSZ:   reg_rdata = 32'(n_badsize);
            ADR_WORDS: reg_rdata = 32'(n_words);
            default:   reg_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/subev_validator_chk.sv
module subev_validator_chk #(
    parameter int WW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [15:0]   out_data,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [WW-1:0] n_words
);
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R11

    AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid); // R2

    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
        (out_ready && !(in_valid && in_ready)) |=> !out_valid); // R2

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd2) |=> (n_words == '0)); // R10

    AST_WORDS_GROW: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == 3'd2) |=> (n_words >= $past(n_words))); // R9
endmodule

bind subev_validator subev_validator_chk #(.WW(WORD_CNT_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .n_words(n_words));

// File: tb/subev_validator_bench.sv
module subev_validator_bench;
    logic        clk = 1'b0, rst = 1'b1;
    logic        in_valid = 1'b0, in_sos = 1'b0, in_eos = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready, out_valid, out_sos, out_eos;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic [17:0] exp_q[$];
    string       tag_q[$];
    logic [17:0] e_w;
    string       t_s;
    int m_under = 0, m_over = 0, m_hdr = 0, m_hsz = 0, m_words = 0;
    int lim_min = 16, lim_max = 65535;
    logic bp_en = 1'b0;

    subev_validator u_subev_validator (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sos(in_sos), .in_eos(in_eos),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sos(out_sos), .out_eos(out_eos), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) out_ready <= bp_en ? (cyc % 3 != 0) : 1'b1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Compare consumed output words against the model queue on every clock
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0)
                    chk("R2 unexpected output word", {14'd0, out_sos, out_eos, out_data}, 32'hFFFF_FFFF);
                else begin
                    e_w = exp_q.pop_front();
                    t_s = tag_q.pop_front();
                    chk(t_s, {14'd0, out_sos, out_eos, out_data}, {14'd0, e_w});
                end
            end
            if (out_valid && !out_ready)
                chk("R11 in_ready while output stalled", {31'd0, in_ready}, 32'd0);
        end
    end

    // Build a subevent, predict its output and counter effects, then drive it
    task automatic send(input int sz, input logic [7:0] fmt, input int n, input logic [15:0] hi);
        logic [15:0] w[$];
        logic hv, tr, sb, fb, un, ov, fl;
        logic [15:0] e;
        string tg;
        for (int i = 0; i < n; i++) begin
            if (i == 0)          w.push_back(16'(sz));
            else if (i == 1)     w.push_back({fmt, 8'h01});
            else if (i == n - 1) w.push_back(hi);
            else                 w.push_back(16'h3000 + 16'(i));
        end
        hv = (n >= 3);
        tr = (n < 3) || (n < sz / 2);
        sb = (sz % 4 != 0) || (sz < 16);
        fb = (fmt != 8'h02);
        un = hv && (sz < lim_min);
        ov = hv && (sz > lim_max);
        fl = tr || un || ov || (hv && (sb || fb));
        for (int i = 0; i < n; i++) begin
            e  = w[i];
            tg = "R2 body word";
            if (i == n - 1) begin
                if (tr) begin e = 16'h0400; tg = "R6 truncated close"; end
                else if (un || ov) begin e = e | 16'h0400; tg = "R3 window flag"; end
                else if (fl) begin e = e | 16'h0400; tg = "R4 header flag"; end
                else tg = "R5 clean close";
            end
            exp_q.push_back({(i == 0), (i == n - 1), e});
            tag_q.push_back(tg);
        end
        if (un) m_under++;
        if (ov) m_over++;
        if (tr || (hv && (sb || fb))) m_hdr++;
        if (hv && sb) m_hsz++;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = w[i];
            in_sos   = (i == 0);
            in_eos   = (i == n - 1);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
            m_words++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sos   = 1'b0;
        in_eos   = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic check_counters();
        rd(3'd3, {m_over[15:0], m_under[15:0]}, "R7 size window counts");
        rd(3'd4, m_hdr, "R8 header failure count");
        rd(3'd5, m_hsz, "R8 byte-count fault count");
        rd(3'd6, m_words, "R9 word count");
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
        chk("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
        rd(3'd0, 32'd16, "R1 lower limit reset");
        rd(3'd1, 32'd65535, "R1 upper limit reset");
        check_counters();

        send(16, 8'h02, 8, 16'h0001);   // clean
        send(16, 8'h03, 8, 16'h0001);   // bad format code
        bp_en = 1'b1;
        send(18, 8'h02, 9, 16'h0002);   // size not multiple of 4
        send(12, 8'h02, 6, 16'h0003);   // size below 16
        send(32, 8'h02, 6, 16'h0004);   // ends early
        send(16, 8'h02, 2, 16'h0005);   // too short for a header
        send(16, 8'h02, 1, 16'h0006);   // single word
        send(20, 8'h02, 10, 16'h0400);  // clean, flag bit already set
        drain();
        bp_en = 1'b0;
        check_counters();

        wr(3'd0, 32'd24);
        wr(3'd1, 32'd40);
        lim_min = 24;
        lim_max = 40;
        rd(3'd0, 32'd24, "R12 lower limit readback");
        rd(3'd1, 32'd40, "R12 upper limit readback");
        bp_en = 1'b1;
        send(16, 8'h02, 8, 16'h0010);   // undersize
        send(44, 8'h02, 22, 16'h0011);  // oversize
        send(32, 8'h02, 16, 16'h0012);  // inside window
        send(40, 8'h02, 20, 16'h0013);  // at upper edge
        send(24, 8'h02, 12, 16'h0014);  // at lower edge
        drain();
        bp_en = 1'b0;
        check_counters();

        wr(3'd2, 32'd0);
        m_under = 0; m_over = 0; m_hdr = 0; m_hsz = 0; m_words = 0;
        rd(3'd3, 32'd0, "R10 size counts cleared");
        rd(3'd4, 32'd0, "R10 header count cleared");
        rd(3'd5, 32'd0, "R10 byte-count faults cleared");
        rd(3'd6, 32'd0, "R10 word count cleared");
        rd(3'd0, 32'd24, "R10 limit kept over clear");

        send(16, 8'h02, 8, 16'h0020);
        drain();
        check_counters();
        finish_run();
    end
endmodule